// File: doc/BRIEF.md
# PWM Compare Output Channel

This block is one output channel of a PWM timer. A shared timebase, which lies outside the block, supplies the running count together with single-cycle strobes. The strobes mark count start, count stop, period match and, in triangle mode, the crest and the trough of the waveform. The channel compares the count against its active 16-bit compare value. It drives one registered output pin according to a separately programmed action for each event: drive low, drive high, keep, or (for the match events) toggle.

A forced-level request holds the pin low or high for whole periods. The request is sampled at a period match and, once latched, overrides every other action until a later period match samples it as inactive. Software can rewrite the active compare value directly at any time. It can also stage a new value in a buffer register, which is copied into the active compare value at each period match (sawtooth mode), or at the crest and/or trough of a triangle waveform, each point enabled on its own. A match flag pulses for one cycle after each counted equality.

Top module: `pwm_cmp_channel`

## Requirements
- R1: After reset, pwmOut and matchFlag are 0, and both the active compare value and the buffer are 0.
- R2: A cntStop or cntStart strobe applies stopAct or startAct, encoded 0 = drive low, 1 = drive high, 2 and 3 = keep. When both strobes arrive in the same cycle, cntStop wins. Both take priority over the match actions.
- R3: The actions on period match (perAct) and on compare match (cmpAct) are encoded 0 = low, 1 = high, 2 = keep, 3 = toggle. A compare match happens when tick is 1 and cnt equals the active compare value. Every action shows on pwmOut at the clock edge after its event.
- R4: When a period match and a compare match happen in the same cycle, only perAct is applied.
- R5: matchFlag is 1 for exactly the cycle after a cycle with tick = 1 and cnt equal to the active compare value. Otherwise it is 0, including while tick = 0.
- R6: forceSel (bit 1 = force, bit 0 = level; values 0 and 1 are inactive, 2 = force low, 3 = force high) is sampled only on periodMatch. From that edge on, a forcing value drives pwmOut to its level and overrides every other action until a later periodMatch samples an inactive value.
- R7: cmpWrEn loads cmpWrData into the active compare value, which is used from the next cycle on.
- R8: In sawtooth mode (triMode = 0) with bufEn = 1, each periodMatch copies the buffer into the active compare value. bufWrEn writes the buffer.
- R9: In triangle mode (triMode = 1) with bufEn = 1, the copy happens on crest when xferCrest = 1 and on trough when xferTrough = 1. periodMatch alone never copies in triangle mode.
- R10: A direct write that coincides with a buffer copy wins. With bufEn = 0 the buffer is never copied.
- R11: In a cycle with no start, stop, period match or compare match, pwmOut holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cnt | input | 16 | Timebase count |
| tick | input | 1 | Count valid for comparison this cycle |
| periodMatch | input | 1 | Period boundary strobe |
| cntStart | input | 1 | Counting started strobe |
| cntStop | input | 1 | Counting stopped strobe |
| triMode | input | 1 | 1 = triangle waveform, 0 = sawtooth |
| crest | input | 1 | Triangle top strobe |
| trough | input | 1 | Triangle bottom strobe |
| startAct | input | 2 | Action on count start |
| stopAct | input | 2 | Action on count stop |
| cmpAct | input | 2 | Action on compare match |
| perAct | input | 2 | Action on period match |
| forceSel | input | 2 | Forced-level request |
| bufEn | input | 1 | Compare buffer enable |
| xferCrest | input | 1 | Buffer copy at crest |
| xferTrough | input | 1 | Buffer copy at trough |
| cmpWrEn | input | 1 | Direct compare write strobe |
| cmpWrData | input | 16 | Direct compare write value |
| bufWrEn | input | 1 | Buffer write strobe |
| bufWrData | input | 16 | Buffer write value |
| pwmOut | output | 1 | Registered output pin |
| matchFlag | output | 1 | Compare match pulse |

## Verification
All sixteen pairings of compare-match and period-match actions run through full sawtooth periods. The compare value moves for each pairing and sometimes lands on the period value, which separates toggle from drive and exposes the priority of the period action. Every pairing of start and stop actions is pulsed alone and together, which shows the encoding of keep and the priority of stop. Forced levels are requested in the middle of a period, so the delay to the next boundary is visible, and start and stop strobes arrive while the force holds. Buffer transfers are tried in sawtooth, in triangle with each of the four crest/trough enable pairings, with the buffer disabled, and against a direct write in the same cycle. The match flag shows which value was active.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int unsigned ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_LOW  = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_KEEP = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  // strobes from control to datapath
  typedef struct packed {
    logic drive;    // load pin with level
    logic level;
    logic flip;     // invert pin
    logic loadBuf;  // copy buffer into active compare
  } pwmc_strobe_t;

  function automatic pwmc_strobe_t decodeAct(input logic [ACT_W-1:0] a,
                                             input logic canFlip);
    pwmc_strobe_t s;
    s = '0;
    case (act_e'(a))
      ACT_LOW:  s.drive = 1'b1;
      ACT_HIGH: begin s.drive = 1'b1; s.level = 1'b1; end
      ACT_FLIP: s.flip = canFlip;
      default:  s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pwmc_ctrl.sv
module pwmc_ctrl
  import pwmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 periodMatch,
  input  logic                 cntStart,
  input  logic                 cntStop,
  input  logic                 cmpHit,
  input  logic                 triMode,
  input  logic                 crest,
  input  logic                 trough,
  input  logic [ACT_W-1:0]     startAct,
  input  logic [ACT_W-1:0]     stopAct,
  input  logic [ACT_W-1:0]     cmpAct,
  input  logic [ACT_W-1:0]     perAct,
  input  logic [1:0]           forceSel,
  input  logic                 bufEn,
  input  logic                 xferCrest,
  input  logic                 xferTrough,
  output pwmc_strobe_t         stb,
  output logic [1:0]           forceHeld
);
  logic [1:0]   forceReg;
  logic [1:0]   forceNext;
  pwmc_strobe_t pinStb;
  logic         xferPoint;

  // force request only changes at a period boundary
  assign forceNext = periodMatch ? forceSel : forceReg;

  always_ff @(posedge clk) begin
    if (!rstN) forceReg <= 2'b00;
    else       forceReg <= forceNext;
  end

  always_comb begin
    pinStb = '0;
    if (forceNext[1]) begin
      pinStb.drive = 1'b1;
      pinStb.level = forceNext[0];
    end else if (cntStop) begin
      pinStb = decodeAct(stopAct, 1'b0);
    end else if (cntStart) begin
      pinStb = decodeAct(startAct, 1'b0);
    end else if (periodMatch) begin
      pinStb = decodeAct(perAct, 1'b1);
    end else if (cmpHit) begin
      pinStb = decodeAct(cmpAct, 1'b1);
    end
  end

  assign xferPoint = triMode ? ((crest & xferCrest) | (trough & xferTrough))
                             : periodMatch;

  always_comb begin
    stb         = pinStb;
    stb.loadBuf = bufEn & xferPoint;
  end

  assign forceHeld = forceReg;
endmodule

// File: rtl/pwmc_dp.sv
module pwmc_dp
  import pwmc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              tick,
  input  pwmc_strobe_t      stb,
  input  logic              cmpWrEn,
  input  logic [CNT_W-1:0]  cmpWrData,
  input  logic              bufWrEn,
  input  logic [CNT_W-1:0]  bufWrData,
  output logic              cmpHit,
  output logic              pwmOut,
  output logic              matchFlag,
  output logic [CNT_W-1:0]  cmpActive,
  output logic [CNT_W-1:0]  bufHeld
);
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0] bufReg;
  logic             pinReg;
  logic             flagReg;

  assign cmpHit = tick && (cnt == cmpReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg <= '0;
      bufReg <= '0;
    end else begin
      if (cmpWrEn)          cmpReg <= cmpWrData;
      else if (stb.loadBuf) cmpReg <= bufReg;
      if (bufWrEn)          bufReg <= bufWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinReg  <= 1'b0;
      flagReg <= 1'b0;
    end else begin
      flagReg <= cmpHit;
      if (stb.drive)     pinReg <= stb.level;
      else if (stb.flip) pinReg <= ~pinReg;
    end
  end

  assign pwmOut    = pinReg;
  assign matchFlag = flagReg;
  assign cmpActive = cmpReg;
  assign bufHeld   = bufReg;
endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwmc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic             periodMatch,
  input  logic             cntStart,
  input  logic             cntStop,
  input  logic             triMode,
  input  logic             crest,
  input  logic             trough,
  input  logic [1:0]       startAct,
  input  logic [1:0]       stopAct,
  input  logic [1:0]       cmpAct,
  input  logic [1:0]       perAct,
  input  logic [1:0]       forceSel,
  input  logic             bufEn,
  input  logic             xferCrest,
  input  logic             xferTrough,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             bufWrEn,
  input  logic [CNT_W-1:0] bufWrData,
  output logic             pwmOut,
  output logic             matchFlag
);
  pwmc_strobe_t     stb;
  logic             cmpHit;
  logic [1:0]       forceHeld;
  logic [CNT_W-1:0] cmpActive;
  logic [CNT_W-1:0] bufHeld;

  pwmc_ctrl u_ctrl (
    .clk, .rstN, .periodMatch, .cntStart, .cntStop, .cmpHit,
    .triMode, .crest, .trough, .startAct, .stopAct, .cmpAct, .perAct,
    .forceSel, .bufEn, .xferCrest, .xferTrough, .stb, .forceHeld
  );

  pwmc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .cnt, .tick, .stb, .cmpWrEn, .cmpWrData, .bufWrEn,
    .bufWrData, .cmpHit, .pwmOut, .matchFlag, .cmpActive, .bufHeld
  );
endmodule

// File: rtl/pwm_cmp_channel_checker.sv
module pwm_cmp_channel_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic             tick,
  input logic             periodMatch,
  input logic             cntStart,
  input logic             cntStop,
  input logic             triMode,
  input logic             crest,
  input logic             trough,
  input logic [1:0]       stopAct,
  input logic [1:0]       forceSel,
  input logic             bufEn,
  input logic             cmpWrEn,
  input logic [CNT_W-1:0] cmpWrData,
  input logic             pwmOut,
  input logic             matchFlag,
  input logic [1:0]       forceHeld,
  input logic [CNT_W-1:0] cmpActive,
  input logic [CNT_W-1:0] bufHeld
);
  a_r5_flag_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cnt == cmpActive) |=> matchFlag);

  a_r5_quiet_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !matchFlag);

  a_r6_force_high: assert property (@(posedge clk) disable iff (!rstN)
    (periodMatch && forceSel == 2'd3) |=> pwmOut);

  a_r6_force_low: assert property (@(posedge clk) disable iff (!rstN)
    (periodMatch && forceSel == 2'd2) |=> !pwmOut);

  a_r2_stop_low: assert property (@(posedge clk) disable iff (!rstN)
    (cntStop && stopAct == 2'd0 && !periodMatch && !forceHeld[1]) |=> !pwmOut);

  a_r7_direct_write: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrEn |=> (cmpActive == $past(cmpWrData)));

  a_r8_saw_transfer: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && !triMode && periodMatch && !cmpWrEn) |=> (cmpActive == $past(bufHeld)));

  a_r9_tri_no_pm_copy: assert property (@(posedge clk) disable iff (!rstN)
    (triMode && !crest && !trough && !cmpWrEn) |=> $stable(cmpActive));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!periodMatch && !cntStart && !cntStop && !(tick && cnt == cmpActive))
      |=> $stable(pwmOut));
endmodule

bind pwm_cmp_channel pwm_cmp_channel_checker #(.CNT_W(CNT_W)) u_chk (
  .clk, .rstN, .cnt, .tick, .periodMatch, .cntStart, .cntStop, .triMode,
  .crest, .trough, .stopAct, .forceSel, .bufEn, .cmpWrEn, .cmpWrData,
  .pwmOut, .matchFlag, .forceHeld, .cmpActive, .bufHeld
);

// File: tb/pwm_cmp_channel_bench.sv
`timescale 1ns/1ps
module pwm_cmp_channel_bench;
  localparam int PER = 7;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cnt;
  logic        tick, periodMatch, cntStart, cntStop, triMode, crest, trough;
  logic [1:0]  startAct, stopAct, cmpAct, perAct, forceSel;
  logic        bufEn, xferCrest, xferTrough, cmpWrEn, bufWrEn;
  logic [15:0] cmpWrData, bufWrData;
  logic        pwmOut, matchFlag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench reference state
  logic        mPwm;
  logic [1:0]  mForce;
  logic [15:0] mCmp, mBuf;
  int          tPos;
  bit          tickGate;
  bit          wrAtPm;
  logic [15:0] wrAtPmVal;
  string       curReq;

  always #5 clk = ~clk;

  pwm_cmp_channel u_pwm_cmp_channel (.*);

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) t=%0t actual=%0b expected=%0b", req, curReq, $time, act, exp);
    end
  endtask

  // one clock: predict, advance, compare
  task automatic cyc();
    logic hit, xf, ePwm;
    logic [1:0] fN;
    string tg;
    hit = tick && (cnt == mCmp);
    fN  = periodMatch ? forceSel : mForce;
    ePwm = mPwm; tg = "R11";
    if (fN[1]) begin ePwm = fN[0]; tg = "R6"; end
    else if (cntStop) begin
      if (stopAct == 2'd0) ePwm = 1'b0; else if (stopAct == 2'd1) ePwm = 1'b1;
      tg = "R2";
    end else if (cntStart) begin
      if (startAct == 2'd0) ePwm = 1'b0; else if (startAct == 2'd1) ePwm = 1'b1;
      tg = "R2";
    end else if (periodMatch) begin
      case (perAct) 2'd0: ePwm = 1'b0; 2'd1: ePwm = 1'b1; 2'd3: ePwm = ~mPwm; default: ; endcase
      tg = hit ? "R4" : "R3";
    end else if (hit) begin
      case (cmpAct) 2'd0: ePwm = 1'b0; 2'd1: ePwm = 1'b1; 2'd3: ePwm = ~mPwm; default: ; endcase
      tg = "R3";
    end
    xf = bufEn && (triMode ? ((crest && xferCrest) || (trough && xferTrough)) : periodMatch);
    if (cmpWrEn) mCmp = cmpWrData;
    else if (xf) mCmp = mBuf;
    if (bufWrEn) mBuf = bufWrData;
    mForce = fN;
    mPwm   = ePwm;
    @(posedge clk); #1;
    check(tg, pwmOut, ePwm);
    check("R5", matchFlag, hit);
  endtask

  // bench timebase: sawtooth 0..PER, triangle 0..PER..1
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      if (triMode) begin
        cnt = 16'(tPos <= PER ? tPos : 2*PER - tPos);
        crest = (tPos == PER);
        trough = (tPos == 0);
        periodMatch = trough;
      end else begin
        cnt = 16'(tPos);
        crest = 1'b0; trough = 1'b0;
        periodMatch = (tPos == PER);
      end
      tick = tickGate;
      if (wrAtPm && periodMatch) begin cmpWrEn = 1'b1; cmpWrData = wrAtPmVal; wrAtPm = 0; end
      cyc();
      cntStart = 0; cntStop = 0; cmpWrEn = 0; bufWrEn = 0;
      tPos = triMode ? ((tPos + 1) % (2*PER)) : ((tPos + 1) % (PER + 1));
    end
  endtask

  initial begin
    rstN = 0; cnt = '0; tick = 0; periodMatch = 0; cntStart = 0; cntStop = 0;
    triMode = 0; crest = 0; trough = 0; startAct = 2; stopAct = 2; cmpAct = 2;
    perAct = 2; forceSel = 0; bufEn = 0; xferCrest = 0; xferTrough = 0;
    cmpWrEn = 0; bufWrEn = 0; cmpWrData = '0; bufWrData = '0;
    mPwm = 0; mForce = 0; mCmp = 0; mBuf = 0; tPos = 0; tickGate = 1;
    wrAtPm = 0; wrAtPmVal = '0; curReq = "R1";
    repeat (3) @(posedge clk);
    #1;
    check("R1", pwmOut, 1'b0);
    check("R1", matchFlag, 1'b0);
    rstN = 1;
    // R1: compare resets to 0, so cnt 0 must hit
    run(2);

    // R3/R4 sweep of match actions with moving compare value
    curReq = "R3";
    for (int ca = 0; ca < 4; ca++) begin
      for (int pa = 0; pa < 4; pa++) begin
        cmpAct = 2'(ca); perAct = 2'(pa);
        cmpWrEn = 1; cmpWrData = 16'((ca*4 + pa) % (PER + 1));
        run(2*(PER + 1));
      end
    end

    // R4: compare value on the period value with flip on compare
    curReq = "R4";
    cmpAct = 3; perAct = 0; cmpWrEn = 1; cmpWrData = 16'(PER);
    run(3*(PER + 1));

    // R2: start/stop encodings and stop-over-start
    curReq = "R2";
    cmpAct = 2; perAct = 2;
    for (int sa = 0; sa < 4; sa++) begin
      for (int so = 0; so < 4; so++) begin
        startAct = 2'(sa); stopAct = 2'(so);
        cntStart = 1; run(2);
        cntStop = 1;  run(2);
        perAct = 1; cntStart = 1; run(1); perAct = 2;
        cntStart = 1; cntStop = 1; run(2);
      end
    end

    // R6: forced levels from the next boundary
    curReq = "R6";
    cmpAct = 3; perAct = 3; startAct = 1; stopAct = 0;
    run(3);
    forceSel = 3; run(2*(PER + 1));
    cntStop = 1; run(2);
    forceSel = 2; run(2*(PER + 1));
    cntStart = 1; run(2);
    forceSel = 1; run(2*(PER + 1));
    forceSel = 0; run(PER + 1);

    // R5: no flag without tick
    curReq = "R5";
    tickGate = 0; run(PER + 3);
    tickGate = 1; run(PER + 1);

    // R7: direct write mid-period
    curReq = "R7";
    cmpWrEn = 1; cmpWrData = 16'd6; run(PER + 1);
    cmpWrEn = 1; cmpWrData = 16'd1; run(PER + 1);

    // R8: sawtooth buffer copy on period match
    curReq = "R8";
    bufEn = 1; bufWrEn = 1; bufWrData = 16'd5; run(2*(PER + 1));
    bufWrEn = 1; bufWrData = 16'd2; run(2*(PER + 1));

    // R10: direct write beats transfer; disabled buffer never copies
    curReq = "R10";
    bufWrEn = 1; bufWrData = 16'd4; run(1);
    wrAtPm = 1; wrAtPmVal = 16'd7; run(2*(PER + 1));
    bufEn = 0; bufWrEn = 1; bufWrData = 16'd3; run(3*(PER + 1));

    // R9: triangle with crest/trough enable pairs
    curReq = "R9";
    triMode = 1; tPos = 0; bufEn = 1;
    for (int xc = 0; xc < 2; xc++) begin
      for (int xt = 0; xt < 2; xt++) begin
        xferCrest = xc[0]; xferTrough = xt[0];
        bufWrEn = 1; bufWrData = 16'(1 + xc*3 + xt*2);
        run(PER);
        bufWrEn = 1; bufWrData = 16'(6 - xc - xt);
        run(3*PER);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (%s) actual=hung expected=finished", curReq);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule